// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block runs the full erase procedure for one or more blocks of an on-chip flash array without software involvement. A start pulse latches a block-selection mask and a prewrite option. If prewrite is requested, the sequencer first programs every byte of the selected blocks to zero. It then issues a timed erase pulse and keeps the watchdog enable asserted for exactly that pulse. After the pulse it scans each still-selected block in ascending order in erase-verify mode.

At every verify address the sequencer writes 0xFF as a dummy byte so that the array latches the address. It waits a settle interval and reads the byte back. A fully read-back block has its bit dropped from the mask, so later pulses erase only the blocks that have not yet verified. A failed read ends the scan and starts another pulse. If the failing scan belongs to the last permitted attempt, the sequencer flags an error instead.

Every duration is a parameter counted in clock cycles: the pulse width, the settle time after entering verify mode, and the settle time after each dummy write. The attempt ceiling is also a parameter. Block `b` occupies addresses `b*BLK_WORDS` through `b*BLK_WORDS+BLK_WORDS-1`.

Top module: `flash_erase_seq`

## Requirements
- R1: While reset is held, and in the idle state afterwards, `busy`, `flash_erase`, `flash_verify`, `flash_we`, `wdog_en`, `flash_addr` and `flash_blk_mask` are all zero, and `done` and `error` are low after reset.
- R2: A `start` sampled while idle latches `blk_sel` and `prewrite_en` and raises `busy` for one launch cycle in which `flash_blk_mask` shows the latched mask. An all-zero mask finishes right after that cycle with `done` set and no erase pulse.
- R3: With prewrite enabled, the cycles after launch write 0x00 (`flash_we`=1, `flash_verify`=0) to every address of every selected block, one address per cycle, with blocks in ascending order. The first erase pulse follows immediately.
- R4: Each erase pulse holds `flash_erase` for exactly T_ERASE cycles. `wdog_en` is high in exactly those cycles. `flash_blk_mask` carries the blocks not yet verified, and only those blocks receive the pulse.
- R5: Directly after a pulse, and again when a block finishes and a further selected block remains, `flash_verify` stays high with `flash_addr` at the block's first address for T_VS1 cycles before the first dummy write.
- R6: Each verify step is one cycle of `flash_we`=1 with `flash_wdata`=0xFF and `flash_verify`=1, then T_VS2 settle cycles, then one read cycle in which `flash_rdata` is sampled. The address is the same throughout the step.
- R7: A read of 0xFF advances to the next address. When the block's last address passes, the block's bit is cleared and the scan moves to the next higher selected block. When no selected block remains, the sequencer goes idle with `done` set.
- R8: A read other than 0xFF drops `flash_verify` and starts a new erase pulse on the next cycle, provided fewer than MAX_TRY pulses have been issued. Blocks verified earlier stay out of the mask.
- R9: A failed read after the MAX_TRY-th pulse returns the sequencer to idle with `error` set and `done` clear. A pass during the scan after that pulse still ends in `done`.
- R10: `done` and `error` hold their values while idle until the next accepted `start`, which clears both. At most one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse, accepted only when idle |
| blk_sel | input | NBLK | Blocks to erase, bit b selects block b |
| prewrite_en | input | 1 | Program zeros over the selected blocks before the first pulse |
| flash_blk_mask | output | NBLK | Block-select mask driven to the array |
| flash_erase | output | 1 | Erase mode strobe |
| flash_verify | output | 1 | Erase-verify mode strobe |
| flash_we | output | 1 | Byte write strobe (prewrite or dummy write) |
| flash_addr | output | clog2(NBLK*BLK_WORDS) | Byte address |
| flash_wdata | output | 8 | Write data |
| flash_rdata | input | 8 | Read data from the array |
| wdog_en | output | 1 | Watchdog enable, high during erase pulses |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence verified every selected block |
| error | output | 1 | Last sequence hit the attempt ceiling |

## Verification
The bench builds the block with five blocks of four bytes each, a 20-cycle pulse, settle times of 5 and 3 cycles, and a ceiling of four attempts. The small durations let every pulse and settle gap be compared cycle by cycle against the reference model within a short run. The small ceiling makes both ends of the attempt range reachable: success on the fourth and final pulse, and an error after four failed pulses. The modelled array gives each block, and separately each block's last byte, its own pulse count before it reads as erased. This covers a failure at the first address, a failure at the last address, and blocks leaving the mask at different attempts.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    typedef enum logic [2:0] {
        FES_IDLE,
        FES_LAUNCH,
        FES_PREWR,
        FES_PULSE,
        FES_VSETUP,
        FES_VDUMMY,
        FES_VSETTLE,
        FES_VREAD
    } fes_state_e;

    localparam logic [7:0] FES_BLANK = 8'hFF;
    localparam logic [7:0] FES_ZERO  = 8'h00;

endpackage

// File: rtl/fes_first_set.sv
module fes_first_set #(
    parameter  int N  = 5,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    // lowest set bit wins: scan downward so the last hit is the lowest
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/fes_blk_span.sv
module fes_blk_span #(
    parameter  int NBLK      = 5,
    parameter  int BLK_WORDS = 256,
    localparam int AW        = $clog2(NBLK * BLK_WORDS),
    localparam int IW        = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] first,
    output logic [AW-1:0] last
);

    logic [AW-1:0] base_tab [NBLK];

    for (genvar g = 0; g < NBLK; g++) begin : g_base
        assign base_tab[g] = AW'(g * BLK_WORDS);
    end

    always_comb begin
        first = '0;
        for (int i = 0; i < NBLK; i++) begin
            if (idx == IW'(i)) first = base_tab[i];
        end
        last = first + AW'(BLK_WORDS - 1);
    end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter  int NBLK      = 5,
    parameter  int BLK_WORDS = 256,
    parameter  int T_ERASE   = 1250000,
    parameter  int T_VS1     = 500,
    parameter  int T_VS2     = 250,
    parameter  int MAX_TRY   = 3000,
    localparam int AW        = $clog2(NBLK * BLK_WORDS),
    localparam int IW        = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int TLONG     = (T_ERASE > T_VS1) ? ((T_ERASE > T_VS2) ? T_ERASE : T_VS2)
                                                 : ((T_VS1 > T_VS2) ? T_VS1 : T_VS2),
    localparam int CW        = $clog2(TLONG + 1),
    localparam int TW        = $clog2(MAX_TRY + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NBLK-1:0] blk_sel,
    input  logic            prewrite_en,
    output logic [NBLK-1:0] flash_blk_mask,
    output logic            flash_erase,
    output logic            flash_verify,
    output logic            flash_we,
    output logic [AW-1:0]   flash_addr,
    output logic [7:0]      flash_wdata,
    input  logic [7:0]      flash_rdata,
    output logic            wdog_en,
    output logic            busy,
    output logic            done,
    output logic            error
);

    typedef struct packed {
        fes_state_e      st;
        logic [NBLK-1:0] mask;
        logic            pre;
        logic [IW-1:0]   blk;
        logic [AW-1:0]   addr;
        logic [CW-1:0]   cnt;
        logic [TW-1:0]   tries;
        logic            done;
        logic            err;
    } fes_regs_t;

    fes_regs_t r_d, r_q;

    // block lookup: lowest pending block, and next pending block above the current one
    logic [NBLK-1:0] upto_bit, above_vec;
    logic            fst_found, nxt_found;
    logic [IW-1:0]   fst_idx, nxt_idx, tgt_idx;
    logic [AW-1:0]   tgt_first, tgt_last_unused, cur_first_unused, cur_last;

    assign upto_bit  = NBLK'(1) << r_q.blk;
    assign above_vec = r_q.mask & ~((upto_bit << 1) - NBLK'(1));

    fes_first_set #(.N(NBLK)) u_fst (.vec(r_q.mask), .found(fst_found), .idx(fst_idx));
    fes_first_set #(.N(NBLK)) u_nxt (.vec(above_vec), .found(nxt_found), .idx(nxt_idx));

    assign tgt_idx = (r_q.st == FES_PREWR || r_q.st == FES_VREAD) ? nxt_idx : fst_idx;

    fes_blk_span #(.NBLK(NBLK), .BLK_WORDS(BLK_WORDS)) u_tgt_span (
        .idx(tgt_idx), .first(tgt_first), .last(tgt_last_unused)
    );
    fes_blk_span #(.NBLK(NBLK), .BLK_WORDS(BLK_WORDS)) u_cur_span (
        .idx(r_q.blk), .first(cur_first_unused), .last(cur_last)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            FES_IDLE: begin
                if (start) begin
                    r_d.st    = FES_LAUNCH;
                    r_d.mask  = blk_sel;
                    r_d.pre   = prewrite_en;
                    r_d.tries = TW'(1);
                    r_d.done  = 1'b0;
                    r_d.err   = 1'b0;
                end
            end
            FES_LAUNCH: begin
                r_d.cnt = '0;
                if (!fst_found) begin
                    r_d.st   = FES_IDLE;
                    r_d.done = 1'b1;
                end else if (r_q.pre) begin
                    r_d.st   = FES_PREWR;
                    r_d.blk  = fst_idx;
                    r_d.addr = tgt_first;
                end else begin
                    r_d.st = FES_PULSE;
                end
            end
            FES_PREWR: begin
                if (r_q.addr != cur_last) begin
                    r_d.addr = r_q.addr + AW'(1);
                end else if (nxt_found) begin
                    r_d.blk  = nxt_idx;
                    r_d.addr = tgt_first;
                end else begin
                    r_d.st  = FES_PULSE;
                    r_d.cnt = '0;
                end
            end
            FES_PULSE: begin
                if (r_q.cnt == CW'(T_ERASE - 1)) begin
                    r_d.st   = FES_VSETUP;
                    r_d.blk  = fst_idx;
                    r_d.addr = tgt_first;
                    r_d.cnt  = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            FES_VSETUP: begin
                if (r_q.cnt == CW'(T_VS1 - 1)) begin
                    r_d.st  = FES_VDUMMY;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            FES_VDUMMY: begin
                r_d.st  = FES_VSETTLE;
                r_d.cnt = '0;
            end
            FES_VSETTLE: begin
                if (r_q.cnt == CW'(T_VS2 - 1)) begin
                    r_d.st  = FES_VREAD;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            FES_VREAD: begin
                r_d.cnt = '0;
                if (flash_rdata == FES_BLANK) begin
                    if (r_q.addr != cur_last) begin
                        r_d.st   = FES_VDUMMY;
                        r_d.addr = r_q.addr + AW'(1);
                    end else begin
                        r_d.mask[r_q.blk] = 1'b0;
                        if (nxt_found) begin
                            r_d.st   = FES_VSETUP;
                            r_d.blk  = nxt_idx;
                            r_d.addr = tgt_first;
                        end else begin
                            r_d.st   = FES_IDLE;
                            r_d.done = 1'b1;
                        end
                    end
                end else if (r_q.tries >= TW'(MAX_TRY)) begin
                    r_d.st  = FES_IDLE;
                    r_d.err = 1'b1;
                end else begin
                    r_d.st    = FES_PULSE;
                    r_d.tries = r_q.tries + TW'(1);
                end
            end
            default: r_d.st = FES_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= FES_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    logic in_verify, addr_live;
    assign in_verify = (r_q.st == FES_VSETUP) || (r_q.st == FES_VDUMMY) ||
                       (r_q.st == FES_VSETTLE) || (r_q.st == FES_VREAD);
    assign addr_live = in_verify || (r_q.st == FES_PREWR);

    assign busy           = (r_q.st != FES_IDLE);
    assign flash_blk_mask = busy ? r_q.mask : '0;
    assign flash_erase    = (r_q.st == FES_PULSE);
    assign wdog_en        = (r_q.st == FES_PULSE);
    assign flash_verify   = in_verify;
    assign flash_we       = (r_q.st == FES_PREWR) || (r_q.st == FES_VDUMMY);
    assign flash_wdata    = (r_q.st == FES_VDUMMY) ? FES_BLANK : FES_ZERO;
    assign flash_addr     = addr_live ? r_q.addr : '0;
    assign done           = r_q.done;
    assign error          = r_q.err;

endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
    parameter int NBLK = 5,
    parameter int AW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [NBLK-1:0] flash_blk_mask,
    input logic            flash_erase,
    input logic            flash_verify,
    input logic            flash_we,
    input logic [AW-1:0]   flash_addr,
    input logic [7:0]      flash_wdata,
    input logic            wdog_en,
    input logic            busy,
    input logic            done,
    input logic            error
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!flash_erase && !flash_verify && !flash_we && !wdog_en && flash_addr == '0)); // R1

    AST_PREWRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_we && !flash_verify) |-> (flash_wdata == 8'h00 && !flash_erase)); // R3

    AST_PULSE_HAS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        flash_erase |-> (flash_blk_mask != '0 && wdog_en && !flash_verify)); // R4

    AST_PULSE_INTO_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_erase) |-> (flash_verify && !flash_we)); // R5

    AST_DUMMY_IS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_we && flash_verify) |-> flash_wdata == 8'hFF); // R6

    AST_DUMMY_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_we && flash_verify) |=> (flash_verify && !flash_we && $stable(flash_addr))); // R6

    AST_MASK_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ((flash_blk_mask & ~$past(flash_blk_mask)) == '0)); // R7

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R10

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(done) && $stable(error))); // R10

endmodule

bind flash_erase_seq fes_checker #(.NBLK(NBLK), .AW(AW)) u_fes_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .flash_blk_mask(flash_blk_mask),
    .flash_erase(flash_erase), .flash_verify(flash_verify), .flash_we(flash_we),
    .flash_addr(flash_addr), .flash_wdata(flash_wdata), .wdog_en(wdog_en),
    .busy(busy), .done(done), .error(error)
);

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;

    localparam int NB  = 5;
    localparam int BW  = 4;
    localparam int TE  = 20;
    localparam int TV1 = 5;
    localparam int TV2 = 3;
    localparam int MT  = 4;
    localparam int AW  = $clog2(NB * BW);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [NB-1:0] blk_sel;
    logic          prewrite_en;
    logic [NB-1:0] flash_blk_mask;
    logic          flash_erase, flash_verify, flash_we, wdog_en, busy, done, error;
    logic [AW-1:0] flash_addr;
    logic [7:0]    flash_wdata;
    logic [7:0]    flash_rdata = 8'h00;

    always #4 clk = ~clk;

    flash_erase_seq #(
        .NBLK(NB), .BLK_WORDS(BW), .T_ERASE(TE), .T_VS1(TV1), .T_VS2(TV2), .MAX_TRY(MT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_sel(blk_sel), .prewrite_en(prewrite_en),
        .flash_blk_mask(flash_blk_mask), .flash_erase(flash_erase), .flash_verify(flash_verify),
        .flash_we(flash_we), .flash_addr(flash_addr), .flash_wdata(flash_wdata),
        .flash_rdata(flash_rdata), .wdog_en(wdog_en), .busy(busy), .done(done), .error(error)
    );

    // ---------------- array model ----------------
    int            need_lo [NB];
    int            need_hi [NB];
    int            pulses  [NB];
    int            total_pulses = 0;
    logic          model_clr = 1'b0;
    logic          prev_er = 1'b0;
    logic [AW-1:0] lat = '0;

    function automatic bit cell_blank(int a);
        int b = a / BW;
        int o = a % BW;
        return pulses[b] >= ((o == BW - 1) ? need_hi[b] : need_lo[b]);
    endfunction

    initial for (int b = 0; b < NB; b++) pulses[b] = 0;

    always @(negedge clk) begin
        if (model_clr) begin
            for (int b = 0; b < NB; b++) pulses[b] = 0;
            total_pulses = 0;
        end
        if (flash_erase && !prev_er) begin
            total_pulses = total_pulses + 1;
            for (int b = 0; b < NB; b++) if (flash_blk_mask[b]) pulses[b] = pulses[b] + 1;
        end
        if (flash_we && flash_verify) lat = flash_addr;
        prev_er = flash_erase;
        flash_rdata = cell_blank(int'(lat)) ? 8'hFF : 8'h00;
    end

    // ---------------- reference model ----------------
    logic          e_busy = 0, e_er = 0, e_vf = 0, e_we = 0, e_done = 0, e_err = 0;
    logic [7:0]    e_wd = 0;
    logic [AW-1:0] e_addr = 0;
    logic [NB-1:0] e_mask = 0;

    task automatic put(input logic bz, input logic er, input logic vf, input logic we,
                       input logic [7:0] wd, input int a, input logic [NB-1:0] m);
        e_busy = bz; e_er = er; e_vf = vf; e_we = we; e_wd = wd; e_addr = AW'(a); e_mask = m;
    endtask

    task automatic model_run();
        logic [NB-1:0] m;
        logic          pre, failed;
        int            tries;
        m = blk_sel; pre = prewrite_en;
        e_done = 0; e_err = 0;
        put(1, 0, 0, 0, 8'h00, 0, m);
        @(posedge clk);
        if (m == '0) begin
            put(0, 0, 0, 0, 8'h00, 0, '0); e_done = 1;
            return;
        end
        if (pre) begin
            for (int b = 0; b < NB; b++) if (m[b]) for (int o = 0; o < BW; o++) begin
                put(1, 0, 0, 1, 8'h00, b * BW + o, m);
                @(posedge clk);
            end
        end
        tries = 1;
        forever begin
            put(1, 1, 0, 0, 8'h00, 0, m);
            repeat (TE) @(posedge clk);
            failed = 0;
            for (int b = 0; b < NB && !failed; b++) begin
                if (m[b]) begin
                    put(1, 0, 1, 0, 8'h00, b * BW, m);
                    repeat (TV1) @(posedge clk);
                    for (int o = 0; o < BW && !failed; o++) begin
                        put(1, 0, 1, 1, 8'hFF, b * BW + o, m);
                        @(posedge clk);
                        put(1, 0, 1, 0, 8'h00, b * BW + o, m);
                        repeat (TV2) @(posedge clk);
                        put(1, 0, 1, 0, 8'h00, b * BW + o, m);
                        @(posedge clk);
                        if (!cell_blank(b * BW + o)) failed = 1;
                    end
                    if (!failed) m[b] = 1'b0;
                end
            end
            if (!failed) begin
                put(0, 0, 0, 0, 8'h00, 0, '0); e_done = 1;
                return;
            end
            if (tries >= MT) begin
                put(0, 0, 0, 0, 8'h00, 0, '0); e_err = 1;
                return;
            end
            tries = tries + 1;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (rst_n === 1'b1 && start === 1'b1) model_run();
        end
    end

    // ---------------- checks, stimulus, watchdog ----------------
    int checks = 0;
    int errors = 0;
    int er_len = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_cycle();
        chk(busy == e_busy, "R2", "busy", busy, e_busy);
        chk(flash_erase == e_er, "R4", "flash_erase", flash_erase, e_er);
        chk(wdog_en == e_er, "R4", "wdog_en", wdog_en, e_er);
        chk(flash_verify == e_vf, "R5", "flash_verify", flash_verify, e_vf);
        chk(flash_we == e_we, "R6", "flash_we", flash_we, e_we);
        if (e_we) chk(flash_wdata == e_wd, "R3", "flash_wdata", flash_wdata, e_wd);
        chk(flash_addr == e_addr, "R7", "flash_addr", flash_addr, e_addr);
        chk(flash_blk_mask == e_mask, "R8", "flash_blk_mask", flash_blk_mask, e_mask);
        chk(done == e_done, "R10", "done", done, e_done);
        chk(error == e_err, "R9", "error", error, e_err);
        if (flash_erase) er_len = er_len + 1;
        else if (er_len != 0) begin
            chk(er_len == TE, "R4", "pulse width", er_len, TE);
            er_len = 0;
        end
    endtask

    task automatic set_need(input int b, input int lo, input int hi);
        need_lo[b] = lo; need_hi[b] = hi;
    endtask

    task automatic clear_array();
        model_clr = 1'b1;
        repeat (2) @(negedge clk);
        model_clr = 1'b0;
    endtask

    task automatic run_case(input logic [NB-1:0] sel, input logic pre);
        @(negedge clk);
        blk_sel = sel; prewrite_en = pre; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        start = 0; blk_sel = '0; prewrite_en = 0; rst_n = 0;
        for (int b = 0; b < NB; b++) set_need(b, 1, 1);
        repeat (3) @(negedge clk);
        chk(!busy && !flash_erase && !flash_verify && !flash_we && !wdog_en, "R1", "strobes in reset", 0, 0);
        chk(flash_addr == '0 && flash_blk_mask == '0, "R1", "addr/mask in reset", flash_addr, 0);
        chk(!done && !error, "R1", "flags in reset", {done, error}, 0);
        rst_n = 1;
        fork
            forever begin
                @(negedge clk);
                compare_cycle();
            end
            begin
                repeat (150000) @(posedge clk);
                errors = errors + 1;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none

        // R2: empty selection
        run_case('0, 1'b1);
        chk(done == 1'b1, "R2", "done on empty mask", done, 1);
        chk(total_pulses == 0, "R2", "no pulse on empty mask", total_pulses, 0);

        // R3 / R7: prewrite, single-pulse success on blocks 1 and 3
        clear_array();
        run_case(5'b01010, 1'b1);
        chk(done == 1'b1, "R7", "done after clean verify", done, 1);
        chk(pulses[1] == 1 && pulses[3] == 1, "R4", "selected blocks pulsed once", pulses[1] + pulses[3], 2);
        chk(pulses[0] + pulses[2] + pulses[4] == 0, "R4", "unselected blocks untouched",
            pulses[0] + pulses[2] + pulses[4], 0);

        // R8 / R9: retries, mid-block failure, success on final allowed pulse
        set_need(0, 1, 1); set_need(2, 3, 3); set_need(4, 2, 4);
        clear_array();
        run_case(5'b10101, 1'b0);
        chk(done == 1'b1 && error == 1'b0, "R9", "success on last permitted pulse", done, 1);
        chk(pulses[0] == 1, "R8", "verified block 0 left out of retries", pulses[0], 1);
        chk(pulses[2] == 3, "R8", "block 2 pulse count", pulses[2], 3);
        chk(pulses[4] == MT, "R8", "block 4 pulse count", pulses[4], MT);

        // R9: attempt ceiling reached
        set_need(3, 9, 9);
        clear_array();
        run_case(5'b01000, 1'b0);
        chk(error == 1'b1 && done == 1'b0, "R9", "error at ceiling", error, 1);
        chk(total_pulses == MT, "R9", "pulses before error", total_pulses, MT);
        repeat (10) @(negedge clk);
        chk(error == 1'b1 && !busy, "R10", "error held while idle", error, 1);

        // R10: next start clears error
        set_need(1, 1, 1);
        clear_array();
        run_case(5'b00010, 1'b1);
        chk(error == 1'b0 && done == 1'b1, "R10", "start clears error", error, 0);
        chk(total_pulses == 1, "R10", "pulses in fresh run", total_pulses, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule